// File: doc/BRIEF.md
# Interrupt Acknowledge and Running-Priority Unit

This block sits between an interrupt controller's selection logic and a processor's register interface. It holds the interrupt ID that the selection logic has picked as the most urgent pending source. It answers acknowledge reads and end-of-interrupt writes. On a successful acknowledge it moves an interrupt from the pending state to the active state. On an end-of-interrupt it retires the interrupt from the active state. Each priority is 8 bits wide. A numerically smaller priority is more urgent.

The block keeps a running-priority register, which the processor reads as the priority of the most urgent interrupt now in service. This value is the smallest priority among all active interrupts, or 0xFF when no interrupt is active. The value is refreshed only after an acknowledge, an end-of-interrupt or a write to the priority array. Bus decoding and the search for the best pending interrupt are outside this block. The selection logic loads its result through `sel_load`/`sel_id`. The ID value 1023 (all ones in 10 bits) is the spurious ID, meaning "nothing to hand out".

Top module: `irq_ack_unit`

## Requirements
- R1: When `ack_rd` is high, both `dist_en` and `cpu_en` are high, and the held ID is below `NUM_IRQ`, the held ID appears on `ack_id` with `ack_vld` high in the cycle after `ack_rd`.
- R2: That successful acknowledge sets the active bit of the ID, clears its pending bit, and makes the held ID spurious, so that a following acknowledge returns 1023.
- R3: When `dist_en` or `cpu_en` is low, an acknowledge returns 1023 and leaves the active vector, the pending vector and the held ID unchanged.
- R4: When both enables are high but the held ID is spurious (or not below `NUM_IRQ`), an acknowledge returns 1023 and changes no state.
- R5: `run_prio` equals the smallest 8-bit priority among active interrupts, or 0xFF when none is active. It takes its new value on the second rising edge after the edge that samples the triggering event.
- R6: `run_prio` is recomputed only after a successful acknowledge, a valid end-of-interrupt, or a pulse on `prio_wr`. A change of `prio_flat` alone does not alter it.
- R7: When `eoi_wr` is high and the active bit of `eoi_id` is set, that active bit is cleared.
- R8: When `eoi_wr` names an ID that is not active, the sticky `eoi_err` flag is set and no other state changes. `eoi_err` stays high until reset.
- R9: `irq` goes high the cycle after `sel_load` loads an ID below `NUM_IRQ` while both enables are high. It goes low after a successful acknowledge, and whenever either enable is low.
- R10: A bit of `pend_set` sets the matching pending bit. When it coincides with the successful acknowledge of that same ID, the pending bit stays set.
- R11: After reset the following hold: the active and pending vectors are zero, `run_prio` is 0xFF, the held ID is spurious, and `irq`, `ack_vld` and `eoi_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dist_en | input | 1 | Distributor enable |
| cpu_en | input | 1 | Processor interface enable |
| prio_flat | input | NUM_IRQ*8 | Priority of each interrupt; ID i occupies bits [8i+7:8i] |
| prio_wr | input | 1 | Pulse: the priority array was written |
| pend_set | input | NUM_IRQ | Per-ID pending set pulses |
| sel_load | input | 1 | Load `sel_id` as the held highest ID |
| sel_id | input | 10 | Highest pending ID from the selection logic |
| ack_rd | input | 1 | Acknowledge read strobe |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | ID carried by the end-of-interrupt write |
| ack_id | output | 10 | Data returned by the last acknowledge |
| ack_vld | output | 1 | `ack_id` updated in this cycle |
| irq | output | 1 | Interrupt request to the processor |
| run_prio | output | 8 | Running priority |
| active_vec | output | NUM_IRQ | Active bit per ID |
| pend_vec | output | NUM_IRQ | Pending bit per ID |
| eoi_err | output | 1 | Sticky flag: end-of-interrupt for an inactive ID |

## Verification
A wrongly held ID shows up on `ack_id` one cycle after the next acknowledge. A wrong active or pending bit is visible on `active_vec` and `pend_vec` right after the edge that made the error. Errors in the active set or in the minimum tree reach `run_prio` two edges after an acknowledge or end-of-interrupt. The bench samples there, so that a stale or early refresh is caught. A refresh triggered outside the allowed events is caught by changing priorities with no `prio_wr` pulse and watching `run_prio` hold.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

   // Outcome of an acknowledge read in the current cycle
   typedef enum logic [1:0] {
      ACK_IDLE      = 2'd0,
      ACK_GRANT     = 2'd1,
      ACK_SPUR_OFF  = 2'd2,
      ACK_SPUR_NONE = 2'd3
   } ack_kind_e;

   // Smaller value means more urgent
   function automatic logic [7:0] more_urgent(input logic [7:0] a, input logic [7:0] b);
      return (a <= b) ? a : b;
   endfunction

endpackage

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
   import irq_ack_pkg::*;
#(
   parameter int NUM_IRQ = 32,
   parameter int ID_W    = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dist_en,
   input  logic            cpu_en,
   input  logic            sel_load,
   input  logic [ID_W-1:0] sel_id,
   input  logic            ack_rd,
   output logic            ack_grant,
   output logic [ID_W-1:0] grant_id,
   output logic [ID_W-1:0] ack_id,
   output logic            ack_vld,
   output logic            irq
);

   localparam logic [ID_W-1:0] SPUR   = {ID_W{1'b1}};
   localparam logic [ID_W-1:0] NUM_ID = ID_W'(NUM_IRQ);

   logic [ID_W-1:0] hold_q;
   logic            both_en;
   logic            hold_ok;
   logic            sel_ok;
   ack_kind_e       kind;

   assign both_en = dist_en & cpu_en;
   assign hold_ok = (hold_q < NUM_ID);
   assign sel_ok  = (sel_id < NUM_ID);

   always_comb begin
      if (!ack_rd)       kind = ACK_IDLE;
      else if (!both_en) kind = ACK_SPUR_OFF;
      else if (!hold_ok) kind = ACK_SPUR_NONE;
      else               kind = ACK_GRANT;
   end

   assign ack_grant = (kind == ACK_GRANT);
   assign grant_id  = hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= SPUR;
         ack_id  <= SPUR;
         ack_vld <= 1'b0;
         irq     <= 1'b0;
      end else begin
         ack_vld <= ack_rd;
         case (kind)
            ACK_GRANT:                   ack_id <= hold_q;
            ACK_SPUR_OFF, ACK_SPUR_NONE: ack_id <= SPUR;
            default:                     ack_id <= ack_id;
         endcase
         if (sel_load)       hold_q <= sel_id;
         else if (ack_grant) hold_q <= SPUR;
         if (sel_load)       irq <= both_en & sel_ok;
         else if (ack_grant) irq <= 1'b0;
         else if (!both_en)  irq <= 1'b0;
      end
   end

   // R1: a granted acknowledge returns the held ID next cycle
   property p_grant_data_r1;
      @(posedge clk) disable iff (!rst_n)
      ack_grant |=> (ack_vld && ack_id == $past(hold_q));
   endproperty
   assert property (p_grant_data_r1);

   // R3: disabled acknowledge returns spurious
   property p_off_spur_r3;
      @(posedge clk) disable iff (!rst_n)
      (ack_rd && !both_en) |=> (ack_id == SPUR);
   endproperty
   assert property (p_off_spur_r3);

   // R3: disabled acknowledge keeps the held ID
   property p_off_hold_r3;
      @(posedge clk) disable iff (!rst_n)
      (ack_rd && !both_en && !sel_load) |=> (hold_q == $past(hold_q));
   endproperty
   assert property (p_off_hold_r3);

   // R9: granted acknowledge drops the request
   property p_grant_drop_irq_r9;
      @(posedge clk) disable iff (!rst_n)
      (ack_grant && !sel_load) |=> !irq;
   endproperty
   assert property (p_grant_drop_irq_r9);

endmodule

// File: rtl/irq_state_track.sv
module irq_state_track #(
   parameter int NUM_IRQ = 32,
   parameter int ID_W    = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] pend_set,
   input  logic               ack_grant,
   input  logic [ID_W-1:0]    grant_id,
   input  logic               eoi_wr,
   input  logic [ID_W-1:0]    eoi_id,
   output logic [NUM_IRQ-1:0] active_q,
   output logic [NUM_IRQ-1:0] pend_q,
   output logic               eoi_done,
   output logic               eoi_err
);

   logic [NUM_IRQ-1:0] ack_mask;
   logic [NUM_IRQ-1:0] eoi_mask;
   logic [NUM_IRQ-1:0] set_act;
   logic [NUM_IRQ-1:0] clr_act;
   logic [NUM_IRQ-1:0] clr_pend;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_dec
      assign ack_mask[i] = (grant_id == ID_W'(i));
      assign eoi_mask[i] = (eoi_id   == ID_W'(i));
   end

   assign eoi_done = eoi_wr & (|(eoi_mask & active_q));
   assign set_act  = ack_grant ? ack_mask : '0;
   assign clr_pend = ack_grant ? ack_mask : '0;
   assign clr_act  = eoi_done  ? eoi_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= '0;
         pend_q   <= '0;
         eoi_err  <= 1'b0;
      end else begin
         active_q <= (active_q & ~clr_act) | set_act;
         pend_q   <= (pend_q & ~clr_pend) | pend_set;
         if (eoi_wr && !eoi_done) eoi_err <= 1'b1;
      end
   end

   // R2: the granted ID is active afterwards
   property p_grant_active_r2;
      @(posedge clk) disable iff (!rst_n)
      ack_grant |=> |(active_q & $past(ack_mask));
   endproperty
   assert property (p_grant_active_r2);

   // R7: a valid end-of-interrupt retires the ID when no grant hits it
   property p_eoi_clear_r7;
      @(posedge clk) disable iff (!rst_n)
      (eoi_done && !ack_grant) |=> !(|(active_q & $past(eoi_mask)));
   endproperty
   assert property (p_eoi_clear_r7);

   // R8: error flag is sticky
   property p_err_sticky_r8;
      @(posedge clk) disable iff (!rst_n)
      eoi_err |=> eoi_err;
   endproperty
   assert property (p_err_sticky_r8);

   // R8: invalid end-of-interrupt leaves active set alone
   property p_eoi_bad_keep_r8;
      @(posedge clk) disable iff (!rst_n)
      (eoi_wr && !eoi_done && !ack_grant) |=> (active_q == $past(active_q));
   endproperty
   assert property (p_eoi_bad_keep_r8);

endmodule

// File: rtl/irq_run_prio.sv
module irq_run_prio
   import irq_ack_pkg::*;
#(
   parameter int NUM_IRQ = 32,
   parameter int PRIO_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IRQ-1:0]        active,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
   input  logic                      recalc,
   output logic [PRIO_W-1:0]         run_prio
);

   localparam int LV = $clog2(NUM_IRQ);
   localparam int P  = 1 << LV;
   localparam logic [PRIO_W-1:0] IDLE = {PRIO_W{1'b1}};

   logic recalc_q;

   for (genvar l = 0; l <= LV; l++) begin : g_lvl
      logic [PRIO_W-1:0] v [P];
      if (l == 0) begin : g_leaf
         for (genvar i = 0; i < P; i++) begin : g_in
            if (i < NUM_IRQ) begin : g_real
               assign v[i] = active[i] ? prio_flat[i*PRIO_W +: PRIO_W] : IDLE;
            end else begin : g_pad
               assign v[i] = IDLE;
            end
         end
      end else begin : g_node
         for (genvar j = 0; j < P; j++) begin : g_cmp
            if (j < (P >> l)) begin : g_use
               assign v[j] = (g_lvl[l-1].v[2*j] <= g_lvl[l-1].v[2*j+1]) ?
                             g_lvl[l-1].v[2*j] : g_lvl[l-1].v[2*j+1];
            end else begin : g_idle
               assign v[j] = IDLE;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         recalc_q <= 1'b0;
         run_prio <= IDLE;
      end else begin
         recalc_q <= recalc;
         if (recalc_q) run_prio <= g_lvl[LV].v[0];
      end
   end

   // R5: nothing active gives the idle priority
   property p_idle_ff_r5;
      @(posedge clk) disable iff (!rst_n)
      (recalc_q && active == '0) |=> (run_prio == IDLE);
   endproperty
   assert property (p_idle_ff_r5);

   // R6: no refresh request, no change
   property p_hold_r6;
      @(posedge clk) disable iff (!rst_n)
      !recalc_q |=> $stable(run_prio);
   endproperty
   assert property (p_hold_r6);

endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
   parameter int NUM_IRQ = 32,
   parameter int PRIO_W  = 8,
   parameter int ID_W    = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      dist_en,
   input  logic                      cpu_en,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
   input  logic                      prio_wr,
   input  logic [NUM_IRQ-1:0]        pend_set,
   input  logic                      sel_load,
   input  logic [ID_W-1:0]           sel_id,
   input  logic                      ack_rd,
   input  logic                      eoi_wr,
   input  logic [ID_W-1:0]           eoi_id,
   output logic [ID_W-1:0]           ack_id,
   output logic                      ack_vld,
   output logic                      irq,
   output logic [PRIO_W-1:0]         run_prio,
   output logic [NUM_IRQ-1:0]        active_vec,
   output logic [NUM_IRQ-1:0]        pend_vec,
   output logic                      eoi_err
);

   if (NUM_IRQ < 2 || NUM_IRQ >= (1 << ID_W)) begin : g_bad_num
      $error("NUM_IRQ must be at least 2 and below the spurious ID");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("PRIO_W must be positive");
   end

   logic            ack_grant;
   logic [ID_W-1:0] grant_id;
   logic            eoi_done;
   logic            recalc;

   irq_ack_ctrl #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .dist_en   (dist_en),
      .cpu_en    (cpu_en),
      .sel_load  (sel_load),
      .sel_id    (sel_id),
      .ack_rd    (ack_rd),
      .ack_grant (ack_grant),
      .grant_id  (grant_id),
      .ack_id    (ack_id),
      .ack_vld   (ack_vld),
      .irq       (irq)
   );

   irq_state_track #(.NUM_IRQ(NUM_IRQ), .ID_W(ID_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_set  (pend_set),
      .ack_grant (ack_grant),
      .grant_id  (grant_id),
      .eoi_wr    (eoi_wr),
      .eoi_id    (eoi_id),
      .active_q  (active_vec),
      .pend_q    (pend_vec),
      .eoi_done  (eoi_done),
      .eoi_err   (eoi_err)
   );

   assign recalc = ack_grant | eoi_done | prio_wr;

   irq_run_prio #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_rprio (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active_vec),
      .prio_flat (prio_flat),
      .recalc    (recalc),
      .run_prio  (run_prio)
   );

   // R10: a pending set pulse always lands
   property p_pend_set_r10;
      @(posedge clk) disable iff (!rst_n)
      (|pend_set) |=> ((pend_vec & $past(pend_set)) == $past(pend_set));
   endproperty
   assert property (p_pend_set_r10);

endmodule

// File: tb/irq_ack_unit_tb.sv
module irq_ack_unit_tb_top;

   localparam int N  = 32;
   localparam int PW = 8;
   localparam int IW = 10;
   localparam logic [IW-1:0] SP = 10'd1023;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dist_en = 1'b0, cpu_en = 1'b0, prio_wr = 1'b0;
   logic sel_load = 1'b0, ack_rd = 1'b0, eoi_wr = 1'b0;
   logic [IW-1:0] sel_id = '0, eoi_id = '0;
   logic [N-1:0] pend_set = '0;
   logic [PW-1:0] prio_b [N];
   logic [N*PW-1:0] prio_flat;
   logic [IW-1:0] ack_id;
   logic ack_vld, irq, eoi_err;
   logic [PW-1:0] run_prio;
   logic [N-1:0] active_vec, pend_vec;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = prio_b[i];
   end

   irq_ack_unit #(.NUM_IRQ(N), .PRIO_W(PW), .ID_W(IW)) dut_i (
      .clk(clk), .rst_n(rst_n), .dist_en(dist_en), .cpu_en(cpu_en),
      .prio_flat(prio_flat), .prio_wr(prio_wr), .pend_set(pend_set),
      .sel_load(sel_load), .sel_id(sel_id), .ack_rd(ack_rd),
      .eoi_wr(eoi_wr), .eoi_id(eoi_id), .ack_id(ack_id), .ack_vld(ack_vld),
      .irq(irq), .run_prio(run_prio), .active_vec(active_vec),
      .pend_vec(pend_vec), .eoi_err(eoi_err)
   );

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [IW-1:0] id);
      @(negedge clk); sel_load = 1'b1; sel_id = id;
      @(negedge clk); sel_load = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk); ack_rd = 1'b1;
      @(negedge clk); ack_rd = 1'b0;
   endtask

   task automatic do_eoi(input logic [IW-1:0] id);
      @(negedge clk); eoi_wr = 1'b1; eoi_id = id;
      @(negedge clk); eoi_wr = 1'b0;
   endtask

   // Vector: {op[1:0], arg[9:0], exp[9:0]}; op 0 load, 1 ack, 2 eoi, 3 check run_prio
   // Priority of ID i is (7*i+3): ID2=17, ID5=38, ID9=66
   localparam int NV = 15;
   localparam logic [21:0] VEC [NV] = '{
      {2'd0, 10'd5,  10'd0},    // load 5
      {2'd1, 10'd0,  10'd5},    // R1 ack returns 5
      {2'd3, 10'd0,  10'd38},   // R5 run prio 38
      {2'd0, 10'd9,  10'd0},    // load 9
      {2'd1, 10'd0,  10'd9},    // R1 ack returns 9
      {2'd3, 10'd0,  10'd38},   // R5 min(38,66)
      {2'd1, 10'd0,  10'd1023}, // R2/R4 held ID now spurious
      {2'd2, 10'd5,  10'd0},    // R7 retire 5
      {2'd3, 10'd0,  10'd66},   // R5 only 9 active
      {2'd0, 10'd2,  10'd0},    // load 2
      {2'd1, 10'd0,  10'd2},    // R1 ack returns 2
      {2'd3, 10'd0,  10'd17},   // R5 min(17,66)
      {2'd2, 10'd9,  10'd0},    // R7 retire 9
      {2'd2, 10'd2,  10'd0},    // R7 retire 2
      {2'd3, 10'd0,  10'd255}   // R5 none active
   };

   initial begin
      for (int i = 0; i < N; i++) prio_b[i] = PW'(7*i + 3);
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(active_vec == '0 && pend_vec == '0, "R11 vectors", {active_vec, pend_vec}, 0);
      chk(run_prio == 8'hFF, "R11 run_prio", run_prio, 8'hFF);
      chk(!irq && !ack_vld && !eoi_err, "R11 flags", {irq, ack_vld, eoi_err}, 0);
      rst_n = 1'b1;
      dist_en = 1'b1; cpu_en = 1'b1;
      do_ack();
      chk(ack_vld && ack_id == SP, "R11 held ID spurious", ack_id, SP);

      // R10 pending set
      @(negedge clk); pend_set = (N'(1) << 2) | (N'(1) << 5) | (N'(1) << 9);
      @(negedge clk); pend_set = '0;
      chk(pend_vec == 32'h0000_0224, "R10 pending set", pend_vec, 32'h224);

      for (int k = 0; k < NV; k++) begin
         case (VEC[k][21:20])
            2'd0: do_load(VEC[k][19:10]);
            2'd1: begin
               do_ack();
               chk(ack_vld && ack_id == VEC[k][9:0], "R1/R2/R4 ack data", ack_id, VEC[k][9:0]);
            end
            2'd2: do_eoi(VEC[k][19:10]);
            default: begin
               @(negedge clk);
               chk(run_prio == VEC[k][7:0], "R5 run_prio", run_prio, VEC[k][7:0]);
            end
         endcase
      end
      // R2 pending bits cleared by the grants, nothing active
      chk(pend_vec == '0, "R2 pending cleared", pend_vec, 0);
      chk(active_vec == '0, "R7 all retired", active_vec, 0);
      chk(!eoi_err, "R8 no error on valid EOIs", eoi_err, 0);

      // R9 request on load
      do_load(10'd4);
      chk(irq, "R9 irq after load", irq, 1);
      // R3 disabled acknowledge
      cpu_en = 1'b0;
      do_ack();
      chk(ack_id == SP, "R3 disabled ack", ack_id, SP);
      chk(active_vec == '0, "R3 no activation", active_vec, 0);
      chk(!irq, "R9 irq low when disabled", irq, 0);
      cpu_en = 1'b1;
      dist_en = 1'b0;
      do_ack();
      chk(ack_id == SP && active_vec == '0, "R3 dist disabled", ack_id, SP);
      dist_en = 1'b1;
      do_ack();
      chk(ack_id == 10'd4, "R3 held ID kept", ack_id, 4);
      chk(active_vec == 32'h10 && !irq, "R2/R9 grant state", {active_vec, irq}, 32'h10 << 1);
      @(negedge clk);
      chk(run_prio == 8'd31, "R5 run_prio 31", run_prio, 31);

      // R6 priority change without write pulse
      prio_b[4] = 8'd1;
      repeat (3) @(negedge clk);
      chk(run_prio == 8'd31, "R6 no refresh", run_prio, 31);
      prio_wr = 1'b1;
      @(negedge clk); prio_wr = 1'b0;
      @(negedge clk);
      chk(run_prio == 8'd1, "R6 refresh on prio_wr", run_prio, 1);

      // R8 end-of-interrupt on inactive ID
      do_eoi(10'd7);
      chk(eoi_err, "R8 error set", eoi_err, 1);
      chk(active_vec == 32'h10, "R8 no change", active_vec, 32'h10);
      do_eoi(10'd4);
      @(negedge clk);
      chk(active_vec == '0 && run_prio == 8'hFF, "R7 retire 4", run_prio, 8'hFF);
      chk(eoi_err, "R8 sticky", eoi_err, 1);

      // R10 pend_set colliding with grant of the same ID
      do_load(10'd6);
      @(negedge clk); ack_rd = 1'b1; pend_set = N'(1) << 6;
      @(negedge clk); ack_rd = 1'b0; pend_set = '0;
      chk(ack_id == 10'd6, "R1 ack 6", ack_id, 6);
      chk(pend_vec[6] && active_vec[6], "R10 set wins", {pend_vec[6], active_vec[6]}, 3);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule